// File: doc/BRIEF.md
# SD Host Command and Status Register Block

This block holds the software-visible command, configuration and status bytes of a simple SD/MMC host. A byte-wide strobe bus writes and reads the registers. A control byte starts a command: it sends a one-cycle start pulse to the command engine, sends a one-cycle pulse that clears the response FIFO, and drives the command type and the transfer direction. The bus-mode, block-length, block-count and interrupt-mask registers drive configuration outputs that the line engines use.

Four status bytes latch event pulses from the command, data and CRC engines. Those engines are outside this block. Software clears a latched bit by writing a one to it. Status byte 0 also shows live copies of the write-protect pin and both card-detect pins. From those pins it derives a card-present flag, and it latches a device-inserted event each time that flag rises. One interrupt line combines the masked bits of status bytes 0 and 1 under a global enable.

Top module: `sdhc_csr`

## Requirements
- R1: After rst_ni is released, every register reads 0x00. Status byte 0 is the exception: it reads only its live pin bits, which are 0 while the pins are low. irq_o, cmd_start_o and fifo_reset_o are low.
- R2: A write to address 0x0 (control) stores bits 7:4 as the command type and bit 2 as the write direction. Bit 0 gives cmd_start_o for exactly one cycle and bit 3 gives fifo_reset_o for exactly one cycle. Both bits read back as 0 after that cycle, and bit 1 is not stored.
- R3: The map is as follows. 0x1 is bus mode and keeps bits 1 (4-bit), 2 (8-bit) and 4 (card power off). 0x2/0x3 are block length low/high. 0x4/0x5 are block count low/high. 0x6 is mask 0 and keeps bits 7:4. 0x7 is mask 1 and keeps bits 7:1. Bits that are not kept read as 0. Block length bits 10:0 drive blk_len_o and bit 11 drives crc_abort_o.
- R4: A pulse on an event input sets the matching bit of its status byte (0x9, 0xA, 0xB), and the bit stays set. In status byte 1, bits 0..7 are: SDIO interrupt, command done, response timeout, auto-stop done, data timeout, response CRC error, read CRC error, write CRC error.
- R5: Writing a 1 to a latched status bit clears it. Writing a 0 leaves it unchanged.
- R6: If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: Status byte 0 (0x8) shows write protect on bit 1, DAT3 detect on bit 2 and GPI detect on bit 3. Each bit follows its pin one cycle after the pin changes, and writes to these bits have no effect.
- R8: Block-length bit 13 selects GPI detect, bit 14 selects DAT3 detect (GPI has priority), and bit 12 sets active-high polarity. Card present (status 0 bit 6) is 1 when a source is selected and its level equals the polarity. A rise of card present latches status 0 bit 7 one cycle later.
- R9: mblk_done_i latches status 0 bit 4 and blk_done_i latches status 0 bit 5.
- R10: irq_o equals block-length bit 15 ANDed with the OR of (status0 & mask0) and (status1 & mask1). Status bytes 2 and 3 and status 1 bit 0 never drive irq_o.
- R11: Writing bus mode with bit 7 set returns every register to 0x00 at that clock edge. Events arriving in the same cycle are dropped.
- R12: rdata_o loads the addressed register on the edge that samples rd_en_i and holds its value otherwise. Addresses 0xC to 0xF read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 4 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| wp_i | input | 1 | Write-protect pin |
| cd_dat3_i | input | 1 | DAT3 card-detect pin |
| cd_gpi_i | input | 1 | GPI card-detect pin |
| mblk_done_i | input | 1 | Multi-block done event |
| blk_done_i | input | 1 | Block done event |
| evt1_i | input | 8 | Status byte 1 events |
| evt2_i | input | 8 | Status byte 2 events |
| evt3_i | input | 8 | Status byte 3 events |
| cmd_start_o | output | 1 | One-cycle command start |
| fifo_reset_o | output | 1 | One-cycle response FIFO clear |
| cmd_type_o | output | 4 | Command type |
| cmd_write_o | output | 1 | Write direction |
| bus_4bit_o | output | 1 | 4-bit bus mode |
| bus_8bit_o | output | 1 | 8-bit bus mode |
| card_pwr_off_o | output | 1 | Card power off |
| blk_len_o | output | 11 | Block size minus one |
| blk_cnt_o | output | 16 | Block count |
| crc_abort_o | output | 1 | Abort on CRC error |
| irq_o | output | 1 | Interrupt request |

## Verification
A write, an event pulse or a soft reset changes the register, the pulse outputs and irq_o on the clock edge that samples it. A pin change takes one edge to reach its status bit and card present, and the inserted-event bit follows one edge after that. A read value appears on rdata_o on the edge that samples rd_en_i. The bench drives inputs on falling edges and checks direct outputs on the next falling edge. After a pin change it waits two idle cycles before it reads. Its monitor compares each read result on the falling edge that follows the sampling edge.

// File: rtl/sdhc_csr_pkg.sv
package sdhc_csr_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int NUM_STS = 4;
  localparam int LEN_W   = 11;
  localparam int CNT_W   = 2 * DATA_W;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL     = 4'h0,
    A_BUSMODE  = 4'h1,
    A_BLKLEN_L = 4'h2,
    A_BLKLEN_H = 4'h3,
    A_BLKCNT_L = 4'h4,
    A_BLKCNT_H = 4'h5,
    A_MASK0    = 4'h6,
    A_MASK1    = 4'h7,
    A_STS0     = 4'h8,
    A_STS1     = 4'h9,
    A_STS2     = 4'hA,
    A_STS3     = 4'hB
  } csr_addr_e;

  // control byte
  localparam int CT_START = 0;
  localparam int CT_WRITE = 2;
  localparam int CT_FRST  = 3;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 8'hFD;
  localparam logic [DATA_W-1:0] CTRL_PULSE = 8'h09;

  // bus mode byte
  localparam int BM_W4   = 1;
  localparam int BM_W8   = 2;
  localparam int BM_POFF = 4;
  localparam int BM_SRST = 7;
  localparam logic [DATA_W-1:0] BM_KEEP = 8'h16;

  // block length word
  localparam int BL_CRC_ABORT = 11;
  localparam int BL_POL_HIGH  = 12;
  localparam int BL_SEL_GPI   = 13;
  localparam int BL_SEL_DAT3  = 14;
  localparam int BL_GIE       = 15;

  localparam logic [DATA_W-1:0] MASK0_KEEP  = 8'hF0;
  localparam logic [DATA_W-1:0] MASK1_KEEP  = 8'hFE;
  localparam logic [DATA_W-1:0] STS0_STICKY = 8'hB0;
endpackage

// File: rtl/sdhc_w1c_byte.sv
module sdhc_w1c_byte #(
  parameter int W = 8,
  parameter logic [W-1:0] STICKY = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '0;
    else if (srst_i) st_q <= '0;
    else             st_q <= (st_q & ~clr_i) | set_i; // event wins
  end

  assign q_o = (st_q & STICKY) | (lvl_i & ~STICKY);

  for (genvar b = 0; b < W; b++) begin : g_chk
    if (STICKY[b]) begin : g_sticky
      AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[b] && !set_i[b] && !srst_i) |=> !q_o[b]); // R5
      AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i[b] && !srst_i) |=> q_o[b]); // R6
    end
  end
endmodule

// File: rtl/sdhc_card_detect.sv
module sdhc_card_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic wp_i,
  input  logic dat3_i,
  input  logic gpi_i,
  input  logic pol_high_i,
  input  logic sel_gpi_i,
  input  logic sel_dat3_i,
  output logic wp_o,
  output logic dat3_o,
  output logic gpi_o,
  output logic present_o,
  output logic insert_o
);
  logic [2:0] pin_q;
  logic       prev_q;
  logic       raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else         pin_q <= {gpi_i, dat3_i, wp_i};
  end

  assign wp_o   = pin_q[0];
  assign dat3_o = pin_q[1];
  assign gpi_o  = pin_q[2];

  // GPI source has priority when both are selected
  assign raw       = sel_gpi_i ? gpi_o : dat3_o;
  assign present_o = (sel_gpi_i | sel_dat3_i) & (raw == pol_high_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= 1'b0;
    else if (srst_i) prev_q <= 1'b0;
    else             prev_q <= present_o;
  end

  assign insert_o = present_o & ~prev_q;

  AST_INSERT_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_o |=> !insert_o); // R8
endmodule

// File: rtl/sdhc_csr.sv
module sdhc_csr
  import sdhc_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              wp_i,
  input  logic              cd_dat3_i,
  input  logic              cd_gpi_i,
  input  logic              mblk_done_i,
  input  logic              blk_done_i,
  input  logic [DATA_W-1:0] evt1_i,
  input  logic [DATA_W-1:0] evt2_i,
  input  logic [DATA_W-1:0] evt3_i,
  output logic              cmd_start_o,
  output logic              fifo_reset_o,
  output logic [3:0]        cmd_type_o,
  output logic              cmd_write_o,
  output logic              bus_4bit_o,
  output logic              bus_8bit_o,
  output logic              card_pwr_off_o,
  output logic [LEN_W-1:0]  blk_len_o,
  output logic [CNT_W-1:0]  blk_cnt_o,
  output logic              crc_abort_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_q, busmode_q, mask0_q, mask1_q, rd_mux;
  logic [CNT_W-1:0]  blklen_q, blkcnt_q;
  logic [NUM_STS-1:0][DATA_W-1:0] sts_set, sts_clr, sts_lvl, sts_q;
  logic srst, cd_wp, cd_dat3, cd_gpi, cd_present, cd_insert;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return wr_en_i && (addr_i == a);
  endfunction

  assign srst = hit(A_BUSMODE) && wdata_i[BM_SRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; busmode_q <= '0; blklen_q <= '0;
      blkcnt_q <= '0; mask0_q <= '0; mask1_q <= '0;
    end else if (srst) begin
      ctrl_q <= '0; busmode_q <= '0; blklen_q <= '0;
      blkcnt_q <= '0; mask0_q <= '0; mask1_q <= '0;
    end else begin
      if (hit(A_CTRL)) ctrl_q <= wdata_i & CTRL_KEEP;
      else             ctrl_q <= ctrl_q & ~CTRL_PULSE; // self-clearing bits
      if (hit(A_BUSMODE))  busmode_q <= wdata_i & BM_KEEP;
      if (hit(A_BLKLEN_L)) blklen_q[DATA_W-1:0] <= wdata_i;
      if (hit(A_BLKLEN_H)) blklen_q[CNT_W-1:DATA_W] <= wdata_i;
      if (hit(A_BLKCNT_L)) blkcnt_q[DATA_W-1:0] <= wdata_i;
      if (hit(A_BLKCNT_H)) blkcnt_q[CNT_W-1:DATA_W] <= wdata_i;
      if (hit(A_MASK0))    mask0_q <= wdata_i & MASK0_KEEP;
      if (hit(A_MASK1))    mask1_q <= wdata_i & MASK1_KEEP;
    end
  end

  sdhc_card_detect u_cd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst),
    .wp_i       (wp_i),
    .dat3_i     (cd_dat3_i),
    .gpi_i      (cd_gpi_i),
    .pol_high_i (blklen_q[BL_POL_HIGH]),
    .sel_gpi_i  (blklen_q[BL_SEL_GPI]),
    .sel_dat3_i (blklen_q[BL_SEL_DAT3]),
    .wp_o       (cd_wp),
    .dat3_o     (cd_dat3),
    .gpi_o      (cd_gpi),
    .present_o  (cd_present),
    .insert_o   (cd_insert)
  );

  assign sts_set[0] = {cd_insert, 1'b0, blk_done_i, mblk_done_i, 4'b0};
  assign sts_set[1] = evt1_i;
  assign sts_set[2] = evt2_i;
  assign sts_set[3] = evt3_i;
  assign sts_lvl[0] = {1'b0, cd_present, 2'b0, cd_gpi, cd_dat3, cd_wp, 1'b0};
  assign sts_lvl[1] = '0;
  assign sts_lvl[2] = '0;
  assign sts_lvl[3] = '0;

  for (genvar k = 0; k < NUM_STS; k++) begin : g_sts
    assign sts_clr[k] = hit(ADDR_W'(int'(A_STS0) + k)) ? wdata_i : '0;
    sdhc_w1c_byte #(
      .W      (DATA_W),
      .STICKY ((k == 0) ? STS0_STICKY : {DATA_W{1'b1}})
    ) u_sts (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .srst_i (srst),
      .set_i  (sts_set[k]),
      .clr_i  (sts_clr[k]),
      .lvl_i  (sts_lvl[k]),
      .q_o    (sts_q[k])
    );
  end

  always_comb begin
    case (addr_i)
      A_CTRL:     rd_mux = ctrl_q;
      A_BUSMODE:  rd_mux = busmode_q;
      A_BLKLEN_L: rd_mux = blklen_q[DATA_W-1:0];
      A_BLKLEN_H: rd_mux = blklen_q[CNT_W-1:DATA_W];
      A_BLKCNT_L: rd_mux = blkcnt_q[DATA_W-1:0];
      A_BLKCNT_H: rd_mux = blkcnt_q[CNT_W-1:DATA_W];
      A_MASK0:    rd_mux = mask0_q;
      A_MASK1:    rd_mux = mask1_q;
      A_STS0:     rd_mux = sts_q[0];
      A_STS1:     rd_mux = sts_q[1];
      A_STS2:     rd_mux = sts_q[2];
      A_STS3:     rd_mux = sts_q[3];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign cmd_start_o    = ctrl_q[CT_START];
  assign fifo_reset_o   = ctrl_q[CT_FRST];
  assign cmd_write_o    = ctrl_q[CT_WRITE];
  assign cmd_type_o     = ctrl_q[DATA_W-1:4];
  assign bus_4bit_o     = busmode_q[BM_W4];
  assign bus_8bit_o     = busmode_q[BM_W8];
  assign card_pwr_off_o = busmode_q[BM_POFF];
  assign blk_len_o      = blklen_q[LEN_W-1:0];
  assign crc_abort_o    = blklen_q[BL_CRC_ABORT];
  assign blk_cnt_o      = blkcnt_q;
  assign irq_o = blklen_q[BL_GIE] & |((sts_q[0] & mask0_q) | (sts_q[1] & mask1_q));

  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_start_o && !(hit(A_CTRL) && wdata_i[CT_START])) |=> !cmd_start_o); // R2
  AST_FRST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_reset_o && !(hit(A_CTRL) && wdata_i[CT_FRST])) |=> !fifo_reset_o); // R2
  AST_SRST_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (blk_len_o == '0 && blk_cnt_o == '0 && !irq_o && !cmd_start_o)); // R11
  AST_GIE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit(A_BLKLEN_H) && !wdata_i[BL_GIE-DATA_W]) |=> !irq_o); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R12
endmodule

// File: tb/sdhc_csr_test.sv
`timescale 1ns/1ps
module sdhc_csr_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic wp = 0, dat3 = 0, gpi = 0, mblk = 0, blk = 0;
  logic [7:0] evt1 = 0, evt2 = 0, evt3 = 0;
  logic cmd_start, fifo_rst, cmd_write, b4, b8, poff, crc_abort, irq;
  logic [3:0] cmd_type;
  logic [10:0] blk_len;
  logic [15:0] blk_cnt;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  sdhc_csr uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .wp_i(wp), .cd_dat3_i(dat3), .cd_gpi_i(gpi),
    .mblk_done_i(mblk), .blk_done_i(blk),
    .evt1_i(evt1), .evt2_i(evt2), .evt3_i(evt3),
    .cmd_start_o(cmd_start), .fifo_reset_o(fifo_rst), .cmd_type_o(cmd_type),
    .cmd_write_o(cmd_write), .bus_4bit_o(b4), .bus_8bit_o(b8),
    .card_pwr_off_o(poff), .blk_len_o(blk_len), .blk_cnt_o(blk_cnt),
    .crc_abort_o(crc_abort), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_evt1(input logic [3:0] a, input logic [7:0] d, input logic [7:0] e);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; evt1 = e;
    @(negedge clk); wr_en = 0; evt1 = 0;
  endtask

  task automatic pulse(input logic [7:0] e1, input logic [7:0] e2, input logic [7:0] e3,
                       input logic m, input logic b);
    @(negedge clk); evt1 = e1; evt2 = e2; evt3 = e3; mblk = m; blk = b;
    @(negedge clk); evt1 = 0; evt2 = 0; evt3 = 0; mblk = 0; blk = 0;
  endtask

  // driver: issue read, push expected item
  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  // monitor: compare each read result on the falling edge after capture
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("R12 unexpected read", 1, 0);
        else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    for (int a = 0; a < 16; a++) rd(4'(a), 8'h00, "R1 reset/R12 map read");
    chk("R1 irq", irq, 0); chk("R1 start", cmd_start, 0); chk("R1 fifo", fifo_rst, 0);

    // R2 control byte
    wr(4'h0, 8'h5D);
    chk("R2 start pulse", cmd_start, 1); chk("R2 fifo pulse", fifo_rst, 1);
    chk("R2 type", cmd_type, 4'h5); chk("R2 dir", cmd_write, 1);
    idle(1);
    chk("R2 start cleared", cmd_start, 0); chk("R2 fifo cleared", fifo_rst, 0);
    rd(4'h0, 8'h54, "R2 ctrl readback");
    wr(4'h0, 8'h02);
    rd(4'h0, 8'h00, "R2 bit1 not stored");

    // R3 configuration registers
    wr(4'h1, 8'h7F);
    chk("R3 4bit", b4, 1); chk("R3 8bit", b8, 1); chk("R3 pwr off", poff, 1);
    rd(4'h1, 8'h16, "R3 busmode");
    wr(4'h2, 8'hFF); wr(4'h3, 8'hFF);
    chk("R3 blk_len", blk_len, 11'h7FF); chk("R3 crc abort", crc_abort, 1);
    rd(4'h3, 8'hFF, "R3 blklen hi");
    wr(4'h4, 8'h34); wr(4'h5, 8'h12);
    chk("R3 blk_cnt", blk_cnt, 16'h1234);
    rd(4'h5, 8'h12, "R3 blkcnt hi");
    wr(4'h6, 8'hFF); rd(4'h6, 8'hF0, "R3 mask0 kept bits");
    wr(4'h7, 8'hFF); rd(4'h7, 8'hFE, "R3 mask1 kept bits");
    wr(4'h3, 8'h00);

    // R4 / R5 / R10 status byte 1 and interrupt
    pulse(8'hA5, 0, 0, 0, 0);
    rd(4'h9, 8'hA5, "R4 sts1 latched");
    chk("R10 gie off", irq, 0);
    wr(4'h3, 8'h80);
    chk("R10 irq on", irq, 1);
    wr(4'h9, 8'h0F);
    rd(4'h9, 8'hA0, "R5 partial clear");
    chk("R10 irq still", irq, 1);
    wr(4'h9, 8'hF0);
    rd(4'h9, 8'h00, "R5 full clear");
    chk("R10 irq cleared", irq, 0);
    wr(4'h7, 8'h00);
    pulse(8'h02, 0, 0, 0, 0);
    chk("R10 masked out", irq, 0);
    wr(4'h7, 8'h02);
    chk("R10 mask enables", irq, 1);
    wr(4'h7, 8'hFE); wr(4'h9, 8'hFF);
    pulse(8'h01, 0, 0, 0, 0);
    chk("R10 sdio bit no irq", irq, 0);
    rd(4'h9, 8'h01, "R4 sdio bit");
    wr(4'h9, 8'hFF);

    // R6 event beats clear
    wr_evt1(4'h9, 8'h08, 8'h08);
    rd(4'h9, 8'h08, "R6 event wins");
    wr(4'h9, 8'hFF);
    rd(4'h9, 8'h00, "R5 clear after R6");

    // R4 / R10 status bytes 2 and 3
    pulse(0, 8'h3C, 8'h81, 0, 0);
    rd(4'hA, 8'h3C, "R4 sts2"); rd(4'hB, 8'h81, "R4 sts3");
    chk("R10 sts2/3 no irq", irq, 0);
    wr(4'hA, 8'hFF); rd(4'hA, 8'h00, "R5 sts2 clear");

    // R9 block events
    pulse(0, 0, 0, 1, 0);
    rd(4'h8, 8'h10, "R9 mblk");
    pulse(0, 0, 0, 0, 1);
    rd(4'h8, 8'h30, "R9 blk");
    chk("R10 sts0 irq", irq, 1);
    wr(4'h8, 8'hFF);
    rd(4'h8, 8'h00, "R5 sts0 clear");
    chk("R10 sts0 irq off", irq, 0);

    // R7 live pin bits
    @(negedge clk); wp = 1; idle(2);
    rd(4'h8, 8'h02, "R7 wp");
    wr(4'h8, 8'hFF);
    rd(4'h8, 8'h02, "R7 write ignored");
    @(negedge clk); dat3 = 1; gpi = 1; idle(2);
    rd(4'h8, 8'h0E, "R7 detect pins");
    chk("R10 level bits no irq", irq, 0);

    // R8 card present and insertion
    wr(4'h3, 8'hB0); idle(1);
    rd(4'h8, 8'hCE, "R8 gpi high present+insert");
    chk("R8 irq", irq, 1);
    wr(4'h8, 8'hFF);
    rd(4'h8, 8'h4E, "R8 insert cleared");
    wr(4'h3, 8'hA0);
    rd(4'h8, 8'h0E, "R8 low polarity absent");
    @(negedge clk); gpi = 0; idle(2);
    rd(4'h8, 8'hC6, "R8 low polarity insert");
    wr(4'h8, 8'hFF);
    rd(4'h8, 8'h46, "R8 insert clear");
    wr(4'h3, 8'hF0); idle(1);
    rd(4'h8, 8'h06, "R8 gpi priority");
    wr(4'h3, 8'hD0); idle(2);
    rd(4'h8, 8'hC6, "R8 dat3 insert");

    // R11 soft reset
    wr_evt1(4'h1, 8'h80, 8'hFF);
    chk("R11 irq", irq, 0); chk("R11 4bit", b4, 0);
    chk("R11 len", blk_len, 0); chk("R11 cnt", blk_cnt, 0);
    rd(4'h9, 8'h00, "R11 events dropped");
    rd(4'h0, 8'h00, "R11 ctrl"); rd(4'h1, 8'h00, "R11 busmode");
    rd(4'h3, 8'h00, "R11 blklen"); rd(4'h7, 8'h00, "R11 mask1");
    rd(4'h8, 8'h06, "R11 sts0 levels only");

    // R12 read hold
    rd(4'h4, 8'h00, "R12 read");
    idle(1);
    wr(4'h4, 8'h55);
    chk("R12 rdata held", rdata, 8'h00);
    rd(4'h4, 8'h55, "R12 new value");

    idle(3);
    chk("R12 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule